// File: doc/BRIEF.md
# Microcoded Bus Sequencer with Wait Freeze

This block runs short, programmable access patterns for an external memory. A pattern is a run of control words held in a small on-chip array. Each bus clock the sequencer presents one word. That word sets the chip-select level and a general-purpose strobe level. It can also raise an internal transfer acknowledge, step a burst address counter, or mark the end of the pattern. Software-side logic loads the array through a simple write port while the sequencer is idle. A one-cycle start pulse then launches a pattern at a chosen index, and the burst counter starts from a supplied base.

A word may carry a wait-enable bit. While such a word is current and the external wait input is seen asserted, the sequencer stays on that word, and its chip-select and strobe levels are held. The mode input selects how the wait input is seen:

- **Asynchronous mode:** the wait input first passes through a two-flop synchronizer, which adds two cycles of release latency.
- **Synchronous mode:** the wait input is sampled raw at the clock edge. A word that carries both wait-enable and acknowledge then yields an early acknowledge on the edge that releases it.

In asynchronous mode such a combined word is a programming mistake, and the block flags it.

Top module: `pattern_sequencer`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `busy` is 0, `cs_n` is 1, `strobe` is 0, `ack` is 0 and `cfg_err` is 0.
- R2: A word is 6 bits. Bit 0 is the chip-select level, bit 1 the strobe level, bit 2 acknowledge, bit 3 wait-enable, bit 4 next-address and bit 5 last. In the cycle after a start pulse taken while idle, the outputs show the word at `start_idx`. With no freeze, the next index follows on each later clock, and `cs_n` and `strobe` equal bits 0 and 1 of the current word.
- R3: `busy` is high from the cycle after an accepted start until one extra cycle after the last-flagged word's final cycle. In that extra cycle `cs_n` is 1 and `strobe` is 0. In the cycle after it, `busy` is 0.
- R4: An accepted start loads `burst_addr` with `start_addr`. The counter rises by one at the clock edge that ends a word with next-address set, so the new value shows with the following word.
- R5: While the current word has wait-enable set and the wait input is seen asserted at a clock edge, the sequencer does not advance, and `cs_n`, `strobe` and `burst_addr` keep their values.
- R6: A word with both wait-enable and next-address set raises `burst_addr` by exactly one, however many cycles it stays frozen.
- R7: In synchronous mode (`wait_async`=0), the first clock edge at which `wait_in` is low releases a frozen word. The next word shows in the cycle after that edge.
- R8: In asynchronous mode (`wait_async`=1), `wait_in` passes through two flops, so a freeze releases two cycles later than it would in synchronous mode.
- R9: A word with acknowledge set and wait-enable clear drives `ack` high in exactly the cycle that word is shown.
- R10: In synchronous mode, a word with acknowledge and wait-enable both set keeps `ack` low while it is shown. `ack` goes high for one cycle, the cycle after the releasing edge. If that word is also last, the pulse falls in the extra busy cycle.
- R11: In asynchronous mode, a word with acknowledge and wait-enable both set drives `cfg_err` high while it is shown and produces no `ack`. In synchronous mode the same word leaves `cfg_err` low.
- R12: While `busy` is high, writes to the array and start pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_async | input | 1 | 1: wait input resynchronized; 0: sampled raw |
| wr_en | input | 1 | Array write strobe (honoured only when idle) |
| wr_idx | input | 4 | Array write index |
| wr_data | input | 6 | Control word to write |
| start | input | 1 | One-cycle launch pulse |
| start_idx | input | 4 | First word index of the pattern |
| start_addr | input | 8 | Burst counter base loaded at launch |
| wait_in | input | 1 | External wait, active high |
| busy | output | 1 | Pattern in progress |
| cs_n | output | 1 | Chip-select level, high when idle |
| strobe | output | 1 | General-purpose strobe level |
| ack | output | 1 | Internal transfer acknowledge pulse |
| cfg_err | output | 1 | Combined wait/acknowledge word seen in asynchronous mode |
| burst_addr | output | 8 | Burst address counter |

## Verification
A wrong word pointer shows one cycle after launch or after any release, as a strobe or chip-select level that does not match the programmed word. A freeze that leaks, or a counter that steps more than once, shows as a changed `burst_addr` or strobe level inside the wait window within the same cycle. A wrong synchronizer depth moves the release by whole cycles, visible in the first sample after the wait input drops. A misplaced early acknowledge or end-of-pattern state shows as an `ack` or `busy` value wrong by a single cycle around the last word.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  // bit 0 is chip-select level, bit 5 is last
  typedef struct packed {
    logic last;
    logic na;
    logic wen;
    logic ack;
    logic strobe;
    logic cs;
  } pword_t;

  localparam int WORD_W = $bits(pword_t);
endpackage

// File: rtl/pseq_store.sv
module pseq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 6,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/pseq_wait.sv
module pseq_wait #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wait_in,
  input  logic async_mode,
  output logic wait_seen
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= wait_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], wait_in};
      end
    end
  endgenerate

  assign wait_seen = async_mode ? chain[STAGES-1] : wait_in;
endmodule

// File: rtl/pseq_burst.sv
module pseq_burst #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + ADDR_W'(1);
  end
endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
  import pseq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [IW-1:0] start_idx,
  input  pword_t        cur,
  input  logic          wait_seen,
  input  logic          async_mode,
  output logic          rd_en,
  output logic [IW-1:0] rd_idx,
  output logic          busy,
  output logic          live,
  output logic          burst_load,
  output logic          burst_step,
  output logic          cs_n,
  output logic          strobe,
  output logic          ack,
  output logic          cfg_err
);
  logic          busy_q, live_q, fin_q, early_q;
  logic [IW-1:0] ptr_q;
  logic          hold, step_ok, launch;
  logic [IW-1:0] next_idx;

  assign launch   = start && !busy_q;
  assign hold     = live_q && cur.wen && wait_seen;
  assign step_ok  = live_q && !hold;
  assign next_idx = ptr_q + IW'(1);

  assign rd_en  = launch || (step_ok && !cur.last);
  assign rd_idx = launch ? start_idx : next_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      live_q  <= 1'b0;
      fin_q   <= 1'b0;
      early_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      early_q <= step_ok && cur.ack && cur.wen && !async_mode;
      if (launch) begin
        busy_q <= 1'b1;
        live_q <= 1'b1;
        ptr_q  <= start_idx;
      end else if (step_ok) begin
        if (cur.last) begin
          live_q <= 1'b0;
          fin_q  <= 1'b1;
        end else begin
          ptr_q <= next_idx;
        end
      end else if (fin_q) begin
        fin_q  <= 1'b0;
        busy_q <= 1'b0;
      end
    end
  end

  assign busy       = busy_q;
  assign live       = live_q;
  assign burst_load = launch;
  assign burst_step = step_ok && cur.na;
  assign cs_n       = live_q ? cur.cs : 1'b1;
  assign strobe     = live_q && cur.strobe;
  assign ack        = (live_q && cur.ack && !cur.wen) || early_q;
  assign cfg_err    = live_q && async_mode && cur.wen && cur.ack;
endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer
  import pseq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wait_async,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  input  logic [IW-1:0]     start_idx,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wait_in,
  output logic              busy,
  output logic              cs_n,
  output logic              strobe,
  output logic              ack,
  output logic              cfg_err,
  output logic [ADDR_W-1:0] burst_addr
);
  logic [WORD_W-1:0] rd_data;
  pword_t            cur;
  logic              rd_en, wait_seen, live, burst_load, burst_step;
  logic [IW-1:0]     rd_idx;
  logic              cur_wen;

  assign cur     = pword_t'(rd_data);
  assign cur_wen = cur.wen;

  pseq_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk(clk), .wr_en(wr_en && !busy), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  pseq_wait #(.STAGES(SYNC_STAGES)) u_wait (
    .clk(clk), .rst(rst), .wait_in(wait_in), .async_mode(wait_async),
    .wait_seen(wait_seen)
  );

  pseq_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst(rst), .load(burst_load), .load_val(start_addr),
    .step(burst_step), .addr(burst_addr)
  );

  pseq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_idx(start_idx), .cur(cur),
    .wait_seen(wait_seen), .async_mode(wait_async), .rd_en(rd_en),
    .rd_idx(rd_idx), .busy(busy), .live(live), .burst_load(burst_load),
    .burst_step(burst_step), .cs_n(cs_n), .strobe(strobe), .ack(ack),
    .cfg_err(cfg_err)
  );
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              start,
  input logic              cs_n,
  input logic              strobe,
  input logic              ack,
  input logic              cfg_err,
  input logic              wait_async,
  input logic              live,
  input logic              cur_wen,
  input logic              wait_seen,
  input logic [ADDR_W-1:0] burst_addr
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !strobe && !ack && !cfg_err));

  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  a_r5_freeze_holds: assert property (@(posedge clk) disable iff (rst)
    (live && cur_wen && wait_seen) |=>
      ($stable(cs_n) && $stable(strobe) && $stable(burst_addr)));

  a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
    busy |=> (burst_addr == $past(burst_addr) ||
              burst_addr == $past(burst_addr) + ADDR_W'(1)));

  a_r11_err_only_async: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (wait_async && !ack));
endmodule

bind pattern_sequencer pseq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .start(start), .cs_n(cs_n),
  .strobe(strobe), .ack(ack), .cfg_err(cfg_err), .wait_async(wait_async),
  .live(live), .cur_wen(cur_wen), .wait_seen(wait_seen),
  .burst_addr(burst_addr)
);

// File: tb/tb_pattern_sequencer.sv
`timescale 1ns/1ps
module tb_pattern_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wait_async = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic [5:0] wr_data = '0;
  logic       start = 1'b0;
  logic [3:0] start_idx = '0;
  logic [7:0] start_addr = '0;
  logic       wait_in = 1'b0;
  logic       busy, cs_n, strobe, ack, cfg_err;
  logic [7:0] burst_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pattern_sequencer dut (
    .clk(clk), .rst(rst), .wait_async(wait_async), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .start(start), .start_idx(start_idx),
    .start_addr(start_addr), .wait_in(wait_in), .busy(busy), .cs_n(cs_n),
    .strobe(strobe), .ack(ack), .cfg_err(cfg_err), .burst_addr(burst_addr)
  );

  function automatic logic [5:0] mk(input logic cs, st, ak, we, na, last);
    return {last, na, we, ak, st, cs};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] idx, input logic [5:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // returns at the sample point of the first cycle of the pattern
  task automatic launch(input logic [3:0] idx, input logic [7:0] base);
    @(negedge clk); start = 1'b1; start_idx = idx; start_addr = base;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 strobe", strobe, 0);
    chk("R1 ack", ack, 0);
    chk("R1 cfg_err", cfg_err, 0);
  endtask

  task automatic t_basic();
    launch(4'd0, 8'd5);
    chk("R2 c1 cs_n", cs_n, 0); chk("R2 c1 strobe", strobe, 1);
    chk("R9 c1 ack", ack, 0);   chk("R4 c1 addr", burst_addr, 5);
    chk("R3 c1 busy", busy, 1);
    @(negedge clk);
    chk("R9 c2 ack", ack, 1);   chk("R2 c2 strobe", strobe, 0);
    @(negedge clk);
    chk("R9 c3 ack", ack, 0);   chk("R4 c3 addr", burst_addr, 5);
    @(negedge clk);
    chk("R2 c4 strobe", strobe, 1); chk("R4 c4 addr", burst_addr, 6);
    @(negedge clk);
    chk("R3 trail busy", busy, 1); chk("R3 trail cs_n", cs_n, 1);
    chk("R3 trail strobe", strobe, 0);
    @(negedge clk);
    chk("R3 end busy", busy, 0); chk("R1 end cs_n", cs_n, 1);
  endtask

  task automatic t_index();
    launch(4'd9, 8'd0);
    chk("R2 idx c1 strobe", strobe, 0); chk("R2 idx c1 cs_n", cs_n, 0);
    @(negedge clk);
    chk("R2 idx c2 strobe", strobe, 1);
    @(negedge clk);
    chk("R3 idx trail", busy, 1); chk("R3 idx cs_n", cs_n, 1);
    @(negedge clk);
    chk("R3 idx end", busy, 0);
  endtask

  task automatic t_busy_ignore();
    launch(4'd0, 8'd5);
    wr_en = 1'b1; wr_idx = 4'd1; wr_data = mk(0,1,0,0,0,0);
    start = 1'b1; start_idx = 4'd9;
    @(negedge clk);
    wr_en = 1'b0; start = 1'b0;
    chk("R12 start ignored ack", ack, 1);
    chk("R12 start ignored strobe", strobe, 0);
    settle();
    launch(4'd0, 8'd5);
    @(negedge clk);
    chk("R12 write ignored strobe", strobe, 0);
    chk("R12 write ignored ack", ack, 1);
    settle();
  endtask

  task automatic t_sync_freeze();
    wait_async = 1'b0; wait_in = 1'b1;
    launch(4'd12, 8'd20);
    chk("R5 c1 strobe", strobe, 1); chk("R5 c1 addr", burst_addr, 20);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 frozen strobe", strobe, 1); chk("R5 frozen cs_n", cs_n, 0);
      chk("R6 frozen addr", burst_addr, 20); chk("R5 frozen ack", ack, 0);
    end
    wait_in = 1'b0;
    @(negedge clk);
    chk("R7 released strobe", strobe, 0); chk("R9 released ack", ack, 1);
    chk("R6 once addr", burst_addr, 21);
    @(negedge clk);
    chk("R6 trail addr", burst_addr, 21); chk("R3 trail busy", busy, 1);
    @(negedge clk);
    chk("R3 end busy", busy, 0);
  endtask

  task automatic t_early_ack();
    wait_async = 1'b0; wait_in = 1'b1;
    launch(4'd14, 8'd0);
    chk("R10 c1 ack", ack, 0);
    @(negedge clk); chk("R10 frozen ack", ack, 0);
    @(negedge clk); chk("R10 frozen ack2", ack, 0); chk("R5 strobe", strobe, 1);
    wait_in = 1'b0;
    @(negedge clk);
    chk("R10 early ack", ack, 1); chk("R10 trail busy", busy, 1);
    chk("R10 trail cs_n", cs_n, 1);
    @(negedge clk);
    chk("R10 ack one cycle", ack, 0); chk("R10 end busy", busy, 0);
    launch(4'd14, 8'd0);
    chk("R10 nofreeze c1 ack", ack, 0);
    @(negedge clk);
    chk("R10 nofreeze ack", ack, 1); chk("R10 nofreeze busy", busy, 1);
    @(negedge clk);
    chk("R10 nofreeze end", busy, 0);
  endtask

  task automatic t_async();
    wait_async = 1'b1; wait_in = 1'b1;
    repeat (3) @(negedge clk);
    launch(4'd4, 8'd0);
    chk("R8 c1 strobe", strobe, 1);
    @(negedge clk);
    chk("R8 frozen strobe", strobe, 1);
    wait_in = 1'b0;
    @(negedge clk); chk("R8 sync lag 1", strobe, 1);
    @(negedge clk); chk("R8 sync lag 2", strobe, 1);
    @(negedge clk); chk("R8 released", strobe, 0);
    settle();
  endtask

  task automatic t_cfg();
    wait_async = 1'b1; wait_in = 1'b0;
    repeat (3) @(negedge clk);
    launch(4'd6, 8'd0);
    chk("R11 async err", cfg_err, 1); chk("R11 async no ack", ack, 0);
    @(negedge clk);
    chk("R11 async trail ack", ack, 0); chk("R11 trail err", cfg_err, 0);
    settle();
    wait_async = 1'b0;
    launch(4'd6, 8'd0);
    chk("R11 sync no err", cfg_err, 0);
    @(negedge clk);
    chk("R10 sync ack", ack, 1);
    settle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    put(4'd0, mk(0,1,0,0,0,0));
    put(4'd1, mk(0,0,1,0,0,0));
    put(4'd2, mk(0,0,0,0,1,0));
    put(4'd3, mk(0,1,0,0,0,1));
    put(4'd9, mk(0,0,0,0,0,0));
    put(4'd10, mk(0,1,0,0,0,1));
    put(4'd12, mk(0,1,0,1,1,0));
    put(4'd13, mk(0,0,1,0,0,1));
    put(4'd14, mk(0,1,1,1,0,1));
    put(4'd4, mk(0,1,0,1,0,0));
    put(4'd5, mk(0,0,0,0,0,1));
    put(4'd6, mk(0,0,1,1,0,1));
    t_basic();
    t_index();
    t_busy_ignore();
    t_sync_freeze();
    t_early_ack();
    t_async();
    t_cfg();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule